// File: doc/BRIEF.md
# Resumable NMI Trap Controller

This block manages entry into and return from a resumable non-maskable interrupt in a hart. A raised request, taken while the block's internal acceptance flag is set, makes it capture the interrupted PC, the cause code and the privilege level into its own shadow CSR set. It then clears the flag, steers fetch to a fixed interrupt handler address and switches to machine mode. Because the regular trap registers are not touched on this path, a handler that interrupts a machine-mode trap handler can still return to it.

While the flag is clear, every other interrupt is held off through a global inhibit output, and a second request is not taken. A synchronous exception raised in that window goes to a separate handler address and writes the regular exception PC, cause and previous-privilege registers, with the previous privilege forced to machine mode. The block decodes the retiring instruction for the dedicated return opcode. In machine mode that return restores PC and privilege from the shadow CSRs and sets the flag again; in any other mode it flags an illegal instruction. Both handler addresses are parameters.

Top module: `nmi_trap_ctrl`

## Requirements
- R1: After reset the acceptance flag is set (`irq_inhibit_o` = 0), the saved-PC, scratch and status-privilege fields are zero, and the cause CSR reads only its top bit set.
- R2: CSRs 0x350 (scratch), 0x351 (saved PC), 0x352 (cause) and 0x353 (status) are read combinationally from `csr_rdata_o`; any other address reads zero. A write (`csr_we_i`) takes effect at the next edge only when `cur_priv_i` is machine mode (2'b11) and the same cycle carries no redirect, no illegal return and no exception; otherwise it changes nothing.
- R3: Bit 0 of the saved-PC CSR always reads 0, both after a software write and after capture on entry.
- R4: The cause CSR always reads bit XLEN-1 as 1, holds the cause code in its low CAUSE_W bits, and reads zero in between.
- R5: The status CSR holds the interrupted privilege in bits [12:11] (00 user, 01 supervisor, 11 machine) and the acceptance flag in bit 3; all other bits read zero. A write of 2'b10 to bits [12:11] leaves that field unchanged.
- R6: A request (`nmi_req_i`) while the flag is set gives, in the same cycle, `redirect_o` = 1, `redirect_pc_o` = NMI_VEC and `priv_o` = 2'b11. From the next cycle the saved PC holds `cur_pc_i` with bit 0 cleared, the cause code holds `nmi_cause_i`, the status field holds `cur_priv_i`, and `irq_inhibit_o` = 1.
- R7: While the flag is clear, `irq_inhibit_o` is 1 and a request causes no redirect and no change to the shadow CSRs.
- R8: A request taken in the same cycle as an exception or a return has priority: the exception writes nothing, the return does not set the flag.
- R9: A retiring instruction equal to 0x70200073 in machine mode, with no request taken and no exception, redirects in the same cycle to the saved PC with `priv_o` = status bits [12:11], and sets the flag at the next edge.
- R10: That return retiring outside machine mode raises `illegal_o`, gives no redirect and leaves the flag unchanged.
- R11: An exception (`exc_valid_i`) while the flag is clear redirects to NMI_EXC_VEC in machine mode and pulses `exc_we_o` with `exc_epc_o` = `cur_pc_i`, `exc_cause_o` = `exc_cause_i`, `exc_mpp_o` = 2'b11. With the flag set the block neither redirects nor pulses `exc_we_o`.
- R12: Machine-mode software reads the flag at status bit 3 and may write it to 0 or 1; `irq_inhibit_o` follows from the next cycle.
- R13: Any other retiring encoding, including the plain machine trap return 0x30200073, does not act as the return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_req_i | input | 1 | Non-maskable interrupt request |
| nmi_cause_i | input | CAUSE_W | Cause code of the request |
| cur_pc_i | input | XLEN | PC of the instruction at the trap point |
| cur_priv_i | input | 2 | Current privilege mode |
| exc_valid_i | input | 1 | Synchronous exception raised this cycle |
| exc_cause_i | input | XLEN | Cause value of that exception |
| retire_valid_i | input | 1 | An instruction retires this cycle |
| retire_instr_i | input | 32 | Encoding of the retiring instruction |
| csr_addr_i | input | 12 | CSR address |
| csr_we_i | input | 1 | CSR write strobe |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data |
| redirect_o | output | 1 | Fetch redirect this cycle |
| redirect_pc_o | output | XLEN | Redirect target |
| priv_o | output | 2 | Privilege mode after the redirect |
| irq_inhibit_o | output | 1 | Global inhibit of all other interrupts |
| illegal_o | output | 1 | Return retired outside machine mode |
| exc_we_o | output | 1 | Write strobe for the regular exception registers |
| exc_epc_o | output | XLEN | Value for the regular exception PC |
| exc_cause_o | output | XLEN | Value for the regular cause register |
| exc_mpp_o | output | 2 | Value for the machine previous-privilege field |

## Verification
The assertions watch on every cycle that no request is taken while the inhibit is raised, that a taken request always redirects to the interrupt vector in machine mode and raises the inhibit at the next edge, that it wins over a simultaneous exception or return, and that a return clears the inhibit. They also keep the saved-PC bit 0 and the cause top bit fixed on reads. Only the bench scenarios show the captured values themselves: the saved PC, cause and privilege after entry, the restore target of a return, the rejected reserved privilege write, writes dropped outside machine mode, and the decode of near-miss encodings.

// File: rtl/rnmi_pkg.sv
package rnmi_pkg;
  localparam logic [1:0]  PRIV_M     = 2'b11;
  localparam logic [1:0]  PRIV_RSV   = 2'b10;
  localparam logic [11:0] CSR_NSCR   = 12'h350;
  localparam logic [11:0] CSR_NEPC   = 12'h351;
  localparam logic [11:0] CSR_NCAUSE = 12'h352;
  localparam logic [11:0] CSR_NSTAT  = 12'h353;
  localparam int          STAT_PP_LO = 11;
  localparam int          STAT_EN    = 3;
  localparam logic [31:0] NRET_ENC   = 32'h7020_0073;
endpackage

// File: rtl/nret_decode.sv
module nret_decode (
  input  logic        retire_valid_i,
  input  logic [31:0] retire_instr_i,
  output logic        is_nret_o
);
  import rnmi_pkg::*;
  // R13: exact match on the full return encoding only
  assign is_nret_o = retire_valid_i && (retire_instr_i == NRET_ENC);
endmodule

// File: rtl/nmi_trap_seq.sv
module nmi_trap_seq #(
  parameter int              XLEN        = 32,
  parameter logic [XLEN-1:0] NMI_VEC     = 32'h8000_0040,
  parameter logic [XLEN-1:0] NMI_EXC_VEC = 32'h8000_0080
) (
  input  logic            nmi_req_i,
  input  logic            exc_valid_i,
  input  logic            is_nret_i,
  input  logic [1:0]      cur_priv_i,
  input  logic            csr_we_i,
  input  logic            en_i,
  input  logic [XLEN-1:0] nepc_i,
  input  logic [1:0]      npp_i,
  output logic            take_nmi_o,
  output logic            take_nexc_o,
  output logic            do_ret_o,
  output logic            illegal_o,
  output logic            csr_wr_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic [1:0]      priv_o
);
  import rnmi_pkg::*;

  logic in_m;

  always_comb begin
    in_m        = (cur_priv_i == PRIV_M);
    // R6/R7/R8: request accepted only with the flag set, ahead of everything
    take_nmi_o  = nmi_req_i && en_i;
    // R11: exceptions inside the handler use the second vector
    take_nexc_o = !take_nmi_o && exc_valid_i && !en_i;
    // R9/R10: return needs machine mode and a clean cycle
    do_ret_o    = !take_nmi_o && !exc_valid_i && is_nret_i && in_m;
    illegal_o   = !take_nmi_o && !exc_valid_i && is_nret_i && !in_m;
    redirect_o  = take_nmi_o || take_nexc_o || do_ret_o;
    if (take_nmi_o) begin
      redirect_pc_o = NMI_VEC;
    end else if (take_nexc_o) begin
      redirect_pc_o = NMI_EXC_VEC;
    end else if (do_ret_o) begin
      redirect_pc_o = nepc_i;
    end else begin
      redirect_pc_o = '0;
    end
    priv_o   = do_ret_o ? npp_i : PRIV_M;
    // R2: software writes only from machine mode in an undisturbed cycle
    csr_wr_o = csr_we_i && in_m && !redirect_o && !illegal_o && !exc_valid_i;
  end
endmodule

// File: rtl/nmi_shadow_csr.sv
module nmi_shadow_csr #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take_nmi_i,
  input  logic               do_ret_i,
  input  logic [XLEN-1:0]    cur_pc_i,
  input  logic [1:0]         cur_priv_i,
  input  logic [CAUSE_W-1:0] nmi_cause_i,
  input  logic               csr_wr_i,
  input  logic [11:0]        csr_addr_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  output logic [XLEN-1:0]    csr_rdata_o,
  output logic               en_o,
  output logic [XLEN-1:0]    nepc_o,
  output logic [1:0]         npp_o
);
  import rnmi_pkg::*;

  logic [XLEN-1:0]    scr_q,  scr_d;
  logic [XLEN-1:1]    epc_q,  epc_d;
  logic [CAUSE_W-1:0] code_q, code_d;
  logic [1:0]         pp_q,   pp_d;
  logic               en_q,   en_d;

  logic [XLEN-1:0] cause_rd, stat_rd;

  always_comb begin
    scr_d  = scr_q;
    epc_d  = epc_q;
    code_d = code_q;
    pp_d   = pp_q;
    en_d   = en_q;
    if (take_nmi_i) begin
      epc_d  = cur_pc_i[XLEN-1:1];          // R3, R6
      code_d = nmi_cause_i;
      pp_d   = cur_priv_i;
      en_d   = 1'b0;
    end else if (do_ret_i) begin
      en_d   = 1'b1;                        // R9
    end else if (csr_wr_i) begin
      case (csr_addr_i)
        CSR_NSCR:   scr_d  = csr_wdata_i;
        CSR_NEPC:   epc_d  = csr_wdata_i[XLEN-1:1];
        CSR_NCAUSE: code_d = csr_wdata_i[CAUSE_W-1:0];
        CSR_NSTAT: begin
          if (csr_wdata_i[STAT_PP_LO+1:STAT_PP_LO] != PRIV_RSV) begin
            pp_d = csr_wdata_i[STAT_PP_LO+1:STAT_PP_LO];   // R5
          end
          en_d = csr_wdata_i[STAT_EN];                     // R12
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scr_q  <= '0;
      epc_q  <= '0;
      code_q <= '0;
      pp_q   <= 2'b00;
      en_q   <= 1'b1;                       // R1
    end else begin
      scr_q  <= scr_d;
      epc_q  <= epc_d;
      code_q <= code_d;
      pp_q   <= pp_d;
      en_q   <= en_d;
    end
  end

  always_comb begin
    cause_rd                = '0;
    cause_rd[XLEN-1]        = 1'b1;         // R4
    cause_rd[CAUSE_W-1:0]   = code_q;
    stat_rd                 = '0;
    stat_rd[STAT_PP_LO+1:STAT_PP_LO] = pp_q;
    stat_rd[STAT_EN]        = en_q;
    case (csr_addr_i)
      CSR_NSCR:   csr_rdata_o = scr_q;
      CSR_NEPC:   csr_rdata_o = {epc_q, 1'b0};
      CSR_NCAUSE: csr_rdata_o = cause_rd;
      CSR_NSTAT:  csr_rdata_o = stat_rd;
      default:    csr_rdata_o = '0;
    endcase
  end

  assign en_o   = en_q;
  assign nepc_o = {epc_q, 1'b0};
  assign npp_o  = pp_q;
endmodule

// File: rtl/nmi_trap_ctrl.sv
module nmi_trap_ctrl #(
  parameter int              XLEN        = 32,
  parameter int              CAUSE_W     = 8,
  parameter logic [XLEN-1:0] NMI_VEC     = 32'h8000_0040,
  parameter logic [XLEN-1:0] NMI_EXC_VEC = 32'h8000_0080
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nmi_req_i,
  input  logic [CAUSE_W-1:0] nmi_cause_i,
  input  logic [XLEN-1:0]    cur_pc_i,
  input  logic [1:0]         cur_priv_i,
  input  logic               exc_valid_i,
  input  logic [XLEN-1:0]    exc_cause_i,
  input  logic               retire_valid_i,
  input  logic [31:0]        retire_instr_i,
  input  logic [11:0]        csr_addr_i,
  input  logic               csr_we_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  output logic [XLEN-1:0]    csr_rdata_o,
  output logic               redirect_o,
  output logic [XLEN-1:0]    redirect_pc_o,
  output logic [1:0]         priv_o,
  output logic               irq_inhibit_o,
  output logic               illegal_o,
  output logic               exc_we_o,
  output logic [XLEN-1:0]    exc_epc_o,
  output logic [XLEN-1:0]    exc_cause_o,
  output logic [1:0]         exc_mpp_o
);
  import rnmi_pkg::*;

  logic            is_nret, take_nmi, take_nexc, do_ret, csr_wr, en;
  logic [XLEN-1:0] nepc;
  logic [1:0]      npp;

  nret_decode u_dec (
    .retire_valid_i (retire_valid_i),
    .retire_instr_i (retire_instr_i),
    .is_nret_o      (is_nret)
  );

  nmi_trap_seq #(.XLEN(XLEN), .NMI_VEC(NMI_VEC), .NMI_EXC_VEC(NMI_EXC_VEC)) u_seq (
    .nmi_req_i     (nmi_req_i),
    .exc_valid_i   (exc_valid_i),
    .is_nret_i     (is_nret),
    .cur_priv_i    (cur_priv_i),
    .csr_we_i      (csr_we_i),
    .en_i          (en),
    .nepc_i        (nepc),
    .npp_i         (npp),
    .take_nmi_o    (take_nmi),
    .take_nexc_o   (take_nexc),
    .do_ret_o      (do_ret),
    .illegal_o     (illegal_o),
    .csr_wr_o      (csr_wr),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .priv_o        (priv_o)
  );

  nmi_shadow_csr #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_csr (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_nmi_i  (take_nmi),
    .do_ret_i    (do_ret),
    .cur_pc_i    (cur_pc_i),
    .cur_priv_i  (cur_priv_i),
    .nmi_cause_i (nmi_cause_i),
    .csr_wr_i    (csr_wr),
    .csr_addr_i  (csr_addr_i),
    .csr_wdata_i (csr_wdata_i),
    .csr_rdata_o (csr_rdata_o),
    .en_o        (en),
    .nepc_o      (nepc),
    .npp_o       (npp)
  );

  // R7: the cleared flag holds off every other interrupt
  assign irq_inhibit_o = !en;
  // R11: regular trap registers written only on the handler-exception path
  assign exc_we_o    = take_nexc;
  assign exc_epc_o   = cur_pc_i;
  assign exc_cause_o = exc_cause_i;
  assign exc_mpp_o   = PRIV_M;
endmodule

// File: rtl/nmi_trap_ctrl_chk.sv
module nmi_trap_ctrl_chk #(
  parameter int              XLEN    = 32,
  parameter logic [XLEN-1:0] NMI_VEC = 32'h8000_0040
) (
  input logic            clk,
  input logic            rst_n,
  input logic            nmi_req_i,
  input logic            exc_valid_i,
  input logic [11:0]     csr_addr_i,
  input logic [XLEN-1:0] csr_rdata_o,
  input logic            redirect_o,
  input logic [XLEN-1:0] redirect_pc_o,
  input logic [1:0]      priv_o,
  input logic            irq_inhibit_o,
  input logic            illegal_o,
  input logic            exc_we_o,
  input logic            take_nmi,
  input logic            do_ret
);
  assert_no_nmi_when_inhibited_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_inhibit_o |-> !take_nmi);

  assert_entry_raises_inhibit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi |=> irq_inhibit_o);

  assert_entry_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi |-> (redirect_o && redirect_pc_o == NMI_VEC && priv_o == 2'b11));

  assert_nmi_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req_i && !irq_inhibit_o && exc_valid_i) |-> (take_nmi && !exc_we_o && !do_ret));

  assert_return_clears_inhibit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    do_ret |=> !irq_inhibit_o);

  assert_illegal_no_redirect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !redirect_o);

  assert_nepc_bit0_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr_i == 12'h351) |-> (csr_rdata_o[0] == 1'b0));

  assert_cause_top_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr_i == 12'h352) |-> csr_rdata_o[XLEN-1]);
endmodule

bind nmi_trap_ctrl nmi_trap_ctrl_chk #(.XLEN(XLEN), .NMI_VEC(NMI_VEC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .nmi_req_i     (nmi_req_i),
  .exc_valid_i   (exc_valid_i),
  .csr_addr_i    (csr_addr_i),
  .csr_rdata_o   (csr_rdata_o),
  .redirect_o    (redirect_o),
  .redirect_pc_o (redirect_pc_o),
  .priv_o        (priv_o),
  .irq_inhibit_o (irq_inhibit_o),
  .illegal_o     (illegal_o),
  .exc_we_o      (exc_we_o),
  .take_nmi      (take_nmi),
  .do_ret        (do_ret)
);

// File: tb/tb_nmi_trap_ctrl.sv
`timescale 1ns/1ps
module tb_nmi_trap_ctrl;
  localparam int          XLEN = 32;
  localparam int          CW   = 8;
  localparam logic [31:0] NV   = 32'h8000_0040;
  localparam logic [31:0] NEV  = 32'h8000_0080;
  localparam logic [31:0] RET  = 32'h7020_0073;
  localparam logic [31:0] MRET = 32'h3020_0073;

  logic clk = 1'b0, rst_n = 1'b0;
  logic nmi_req = 0; logic [CW-1:0] nmi_cause = '0;
  logic [31:0] cur_pc = '0; logic [1:0] cur_priv = 2'b11;
  logic exc_valid = 0; logic [31:0] exc_cause = '0;
  logic rv = 0; logic [31:0] instr = '0;
  logic [11:0] caddr = '0; logic cwe = 0; logic [31:0] cwdata = '0;
  logic [31:0] rdata, rpc, eepc, ecause;
  logic redir, inhibit, illegal, ewe; logic [1:0] privo, empp;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  logic [31:0] m_scr = '0, m_epc = '0; logic [CW-1:0] m_code = '0;
  logic [1:0] m_pp = 2'b00; logic m_en = 1'b1;

  always #10 clk = ~clk;

  nmi_trap_ctrl #(.XLEN(XLEN), .CAUSE_W(CW), .NMI_VEC(NV), .NMI_EXC_VEC(NEV)) dut (
    .clk(clk), .rst_n(rst_n), .nmi_req_i(nmi_req), .nmi_cause_i(nmi_cause),
    .cur_pc_i(cur_pc), .cur_priv_i(cur_priv), .exc_valid_i(exc_valid), .exc_cause_i(exc_cause),
    .retire_valid_i(rv), .retire_instr_i(instr), .csr_addr_i(caddr), .csr_we_i(cwe),
    .csr_wdata_i(cwdata), .csr_rdata_o(rdata), .redirect_o(redir), .redirect_pc_o(rpc),
    .priv_o(privo), .irq_inhibit_o(inhibit), .illegal_o(illegal), .exc_we_o(ewe),
    .exc_epc_o(eepc), .exc_cause_o(ecause), .exc_mpp_o(empp));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_read(logic [11:0] a);
    case (a)
      12'h350: return m_scr;
      12'h351: return {m_epc[31:1], 1'b0};
      12'h352: return {1'b1, 23'd0, m_code};
      12'h353: return {19'd0, m_pp, 7'd0, m_en, 3'd0};
      default: return 32'd0;
    endcase
  endfunction

  task automatic cyc(string rtag, logic nmi, logic [CW-1:0] nc, logic [31:0] pc, logic [1:0] pv,
                     logic ex, logic [31:0] ec, logic r, logic [31:0] ins,
                     logic we, logic [11:0] a, logic [31:0] wd);
    logic is_ret, t_nmi, t_nexc, t_ret, t_ill, e_redir, wr_ok;
    logic [31:0] e_pc; logic [1:0] e_priv; string etag;
    @(negedge clk);
    nmi_req = nmi; nmi_cause = nc; cur_pc = pc; cur_priv = pv; exc_valid = ex; exc_cause = ec;
    rv = r; instr = ins; cwe = we; caddr = a; cwdata = wd;
    #2;
    is_ret = r && (ins == RET);
    t_nmi  = nmi && m_en;
    t_nexc = !t_nmi && ex && !m_en;
    t_ret  = !t_nmi && !ex && is_ret && (pv == 2'b11);
    t_ill  = !t_nmi && !ex && is_ret && (pv != 2'b11);
    e_redir = t_nmi || t_nexc || t_ret;
    e_pc   = t_nmi ? NV : (t_nexc ? NEV : {m_epc[31:1], 1'b0});
    e_priv = t_ret ? m_pp : 2'b11;
    etag = t_nmi ? "R6/R8" : (t_nexc ? "R11" : (t_ret ? "R9" : (t_ill ? "R10" : rtag)));
    chk(etag, {31'd0, redir}, {31'd0, e_redir});
    if (e_redir) begin
      chk(etag, rpc, e_pc);
      chk(etag, {30'd0, privo}, {30'd0, e_priv});
    end
    chk(etag, {31'd0, illegal}, {31'd0, t_ill});
    chk((t_nexc || ex) ? "R11" : etag, {31'd0, ewe}, {31'd0, t_nexc});
    if (t_nexc) begin
      chk("R11", eepc, pc); chk("R11", ecause, ec); chk("R11", {30'd0, empp}, 32'd3);
    end
    chk(m_en ? rtag : "R7", {31'd0, inhibit}, {31'd0, !m_en});
    chk(rtag, rdata, model_read(a));
    wr_ok = we && (pv == 2'b11) && !e_redir && !t_ill && !ex;
    if (t_nmi) begin
      m_epc = {pc[31:1], 1'b0}; m_code = nc; m_pp = pv; m_en = 1'b0;
    end else if (t_ret) begin
      m_en = 1'b1;
    end else if (wr_ok) begin
      case (a)
        12'h350: m_scr = wd;
        12'h351: m_epc = {wd[31:1], 1'b0};
        12'h352: m_code = wd[CW-1:0];
        12'h353: begin
          if (wd[12:11] != 2'b10) m_pp = wd[12:11];
          m_en = wd[3];
        end
        default: ;
      endcase
    end
  endtask

  // read-only idle cycle in machine mode
  task automatic rd(string tag, logic [11:0] a);
    cyc(tag, 0, '0, 32'h100, 2'b11, 0, '0, 0, '0, 0, a, '0);
  endtask
  task automatic wr(string tag, logic [1:0] pv, logic [11:0] a, logic [31:0] wd);
    cyc(tag, 0, '0, 32'h100, pv, 0, '0, 0, '0, 1, a, wd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] addrs [5];
    logic [1:0]  privs [3];
    addrs = '{12'h350, 12'h351, 12'h352, 12'h353, 12'h340};
    privs = '{2'b00, 2'b01, 2'b11};
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state
    rd("R1", 12'h353); rd("R1", 12'h352); rd("R1", 12'h351); rd("R1", 12'h350);
    // R2: map, write gating, unmapped address
    wr("R2", 2'b11, 12'h350, 32'hDEAD_BEEF); rd("R2", 12'h350);
    wr("R2", 2'b00, 12'h350, 32'h0000_1234); rd("R2", 12'h350);
    wr("R2", 2'b01, 12'h340, 32'hFFFF_FFFF); rd("R2", 12'h340);
    // R3: saved PC bit 0
    wr("R3", 2'b11, 12'h351, 32'h0000_1003); rd("R3", 12'h351);
    // R4: cause shape
    wr("R4", 2'b11, 12'h352, 32'hFFFF_FFFF); rd("R4", 12'h352);
    wr("R4", 2'b11, 12'h352, 32'h0000_0000); rd("R4", 12'h352);
    // R5: status field, reserved encoding rejected
    wr("R5", 2'b11, 12'h353, 32'hFFFF_FFFF); rd("R5", 12'h353);
    wr("R5", 2'b11, 12'h353, 32'h0000_1008); rd("R5", 12'h353);
    // R6/R8: request from user mode together with exception and return
    cyc("R8", 1, 8'h05, 32'h4000_0101, 2'b00, 1, 32'h2, 1, RET, 1, 12'h351, 32'h0);
    rd("R6", 12'h351); rd("R6", 12'h352); rd("R6", 12'h353);
    // R7: second request ignored
    cyc("R7", 1, 8'h09, 32'h8000_0044, 2'b11, 0, '0, 0, '0, 0, 12'h352, '0);
    rd("R7", 12'h351);
    // R11: exception inside handler
    cyc("R11", 0, '0, 32'h8000_0048, 2'b11, 1, 32'h0000_0005, 0, '0, 0, 12'h353, '0);
    // R10: return outside machine mode
    cyc("R10", 0, '0, 32'h8000_004C, 2'b01, 0, '0, 1, RET, 0, 12'h353, '0);
    // R13: near-miss encodings
    cyc("R13", 0, '0, 32'h8000_0050, 2'b11, 0, '0, 1, MRET, 0, 12'h353, '0);
    cyc("R13", 0, '0, 32'h8000_0050, 2'b11, 0, '0, 1, RET ^ 32'h4000_0000 ^ 32'h1000_0000, 0, 12'h353, '0);
    // R9: return in machine mode
    cyc("R9", 0, '0, 32'h8000_0054, 2'b11, 0, '0, 1, RET, 0, 12'h353, '0);
    rd("R9", 12'h353);
    // R11: exception with flag set does nothing here
    cyc("R11", 0, '0, 32'h0000_2000, 2'b00, 1, 32'h0000_000D, 0, '0, 0, 12'h353, '0);
    // R12: software clears and sets the flag
    wr("R12", 2'b11, 12'h353, 32'h0000_0000); rd("R12", 12'h353);
    wr("R12", 2'b11, 12'h353, 32'h0000_0808); rd("R12", 12'h353);
    // random mix
    void'($urandom(32'd2024));
    for (int i = 0; i < 4000; i++) begin
      logic n, e, r, w; logic [31:0] ins;
      n = ($urandom % 8) == 0;
      e = ($urandom % 10) == 0;
      r = ($urandom % 4) == 0;
      w = ($urandom % 3) == 0;
      case ($urandom % 3)
        0: ins = RET;
        1: ins = MRET;
        default: ins = $urandom;
      endcase
      cyc("R2", n, 8'($urandom), $urandom, privs[$urandom % 3], e, $urandom, r, ins,
          w, addrs[$urandom % 5], $urandom);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule